// File: doc/BRIEF.md
# Sequential linear SVM classifier

This block decides whether one feature vector belongs to the seizure class. It uses a stored linear support vector machine that holds only the support vectors whose multipliers are nonzero. Three read-only tables are filled from parameters:
- the support vector coordinates,
- the multiplier magnitudes with a sign bit,
- one label bit per support vector.

A controller walks the tables. It drives one multiplier and one adder to form, for every support vector, the dot product of the input with that vector. Each dot product is then scaled by the signed multiplier and summed. The bias is preloaded into the running sum.

The user presents a packed feature vector and pulses `start`. The vector is captured on that edge. A fixed number of cycles later, `valid` pulses for one cycle. `seizure` then carries the class, and it holds that class until the next result. Start strobes that arrive while a classification is running have no effect. A strobe that arrives in the cycle `valid` is high begins the next classification.

Top module: `svm_lin_classify`

## Requirements
- R1: While reset is held and after it is released, `valid` and `seizure` are 0.
- R2: Feature f of the input is taken from `feat_in[f*W +: W]`, as a two's complement value. Coordinate f of support vector s is word s*NFEAT+f of `SV_INIT`, also two's complement. Word s of `ALPHA_INIT` is a sign-magnitude value whose MSB is the sign. A label bit of 1 means the support vector is of the negative class.
- R3: For each support vector, the dot product is accumulated at full precision over the features. Bits [FRAC+W-1:FRAC] of that sum are taken as a W-bit two's complement value q.
- R4: The term for a support vector is (alpha magnitude × q) shifted right arithmetically by FRAC. It is negated when the alpha sign bit XOR the label bit is 1, and then added to a running sum that starts at the sign-extended `BIAS`.
- R5: `seizure` is 1 when the final sum is strictly positive. A sum of exactly zero, or a negative sum, gives 0.
- R6: `valid` is high for exactly one cycle per result. `seizure` does not change while `valid` is low.
- R7: `valid` is high in the cycle that follows NSV*(NFEAT+1)+1 rising edges after the edge that accepted `start`. With 4 support vectors and 3 features, that is 17 edges.
- R8: The vector is latched on the accepting edge. Later changes of `feat_in` do not affect the result.
- R9: A `start` strobe during a running classification is ignored. It neither restarts the count nor alters the result.
- R10: A `start` strobe in the cycle where `valid` is high is accepted as a new classification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Strobe that requests a classification of `feat_in` |
| feat_in | input | NFEAT*W | Packed two's complement feature vector |
| seizure | output | 1 | Class of the last result, 1 for seizure |
| valid | output | 1 | One-cycle pulse marking a new result |

## Verification
Two functions can fall in the same cycle: the issue of one result through `valid`, and the acceptance of the next `start`. The bench provokes this by raising `start` with a new vector in exactly the cycle where `valid` is high. It then requires the first class to match its own model of the first vector. It also requires the second result to appear after the full latency with the class of the second vector. A second collision is also exercised: a `start` raised in the middle of a run, together with a changed `feat_in`. The bench judges it by an unchanged latency and by a class computed from the originally latched vector.

// File: rtl/svm_lin_classify.sv
module svm_lin_classify #(
  parameter int W     = 16,
  parameter int NFEAT = 3,
  parameter int NSV   = 4,
  parameter int FRAC  = 8,
  parameter logic [NSV*NFEAT*W-1:0] SV_INIT = {16'h0080, 16'hff00, 16'hff00,
                                               16'hfe70, 16'h0032, 16'h0032,
                                               16'h0064, 16'h012c, 16'hff38,
                                               16'h0040, 16'hff80, 16'h0100},
  parameter logic [NSV*W-1:0] ALPHA_INIT = {16'h0020, 16'h00c8, 16'h0040, 16'h0080},
  parameter logic [NSV-1:0]   LABEL_INIT = 4'b1010,
  parameter logic [W-1:0]     BIAS       = 16'hffc0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [NFEAT*W-1:0] feat_in,
  output logic               seizure,
  output logic               valid
);
  localparam int FIW = (NFEAT > 1) ? $clog2(NFEAT) : 1;
  localparam int SIW = (NSV > 1) ? $clog2(NSV) : 1;
  localparam int SAW = (NSV*NFEAT > 1) ? $clog2(NSV*NFEAT) : 1;
  localparam int AW  = 2*W + FIW + SIW + 2;

  typedef enum logic [1:0] {ST_IDLE, ST_DOT, ST_SCALE, ST_FIN} st_t;

  logic [W-1:0] sv_rom    [NSV*NFEAT];
  logic [W-1:0] alpha_rom [NSV];
  logic         lbl_rom   [NSV];

  for (genvar g = 0; g < NSV*NFEAT; g++) begin : g_sv
    assign sv_rom[g] = SV_INIT[g*W +: W];
  end
  for (genvar g = 0; g < NSV; g++) begin : g_al
    assign alpha_rom[g] = ALPHA_INIT[g*W +: W];
    assign lbl_rom[g]   = LABEL_INIT[g];
  end

  st_t                 state_q;
  logic [FIW-1:0]      f_q;
  logic [SIW-1:0]      s_q;
  logic [NFEAT*W-1:0]  x_q;
  logic signed [AW-1:0] dot_q, sum_q;
  logic [W-1:0]        ay_q;

  wire busy = (state_q != ST_IDLE);
  wire take = start & ~busy;
  wire in_dot = (state_q == ST_DOT);

  logic [SAW-1:0] sv_addr;
  assign sv_addr = SAW'(int'(s_q) * NFEAT + int'(f_q));

  logic signed [W-1:0]   op_a, op_b;
  logic signed [2*W-1:0] prod;
  logic signed [AW-1:0]  prod_x, shifted, addend, acc_in;

  assign op_a    = in_dot ? $signed(x_q[f_q*W +: W]) : $signed({1'b0, ay_q[W-2:0]});
  assign op_b    = in_dot ? $signed(sv_rom[sv_addr]) : $signed(dot_q[FRAC +: W]);
  assign prod    = op_a * op_b;
  assign prod_x  = {{(AW-2*W){prod[2*W-1]}}, prod};
  assign shifted = prod_x >>> FRAC;
  assign addend  = in_dot ? prod_x : (ay_q[W-1] ? -shifted : shifted);
  assign acc_in  = (in_dot ? dot_q : sum_q) + addend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      f_q     <= '0;
      s_q     <= '0;
      x_q     <= '0;
      dot_q   <= '0;
      sum_q   <= '0;
      ay_q    <= '0;
      seizure <= 1'b0;
      valid   <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (state_q)
        ST_IDLE: if (take) begin
          x_q     <= feat_in;
          f_q     <= '0;
          s_q     <= '0;
          dot_q   <= '0;
          sum_q   <= {{(AW-W){BIAS[W-1]}}, BIAS};
          state_q <= ST_DOT;
        end
        ST_DOT: begin
          dot_q <= acc_in;
          if (f_q == '0)
            ay_q <= {alpha_rom[s_q][W-1] ^ lbl_rom[s_q], alpha_rom[s_q][W-2:0]};
          if (f_q == FIW'(NFEAT-1)) begin
            f_q     <= '0;
            state_q <= ST_SCALE;
          end else begin
            f_q <= f_q + 1'b1;
          end
        end
        ST_SCALE: begin
          sum_q <= acc_in;
          dot_q <= '0;
          if (s_q == SIW'(NSV-1)) begin
            state_q <= ST_FIN;
          end else begin
            s_q     <= s_q + 1'b1;
            state_q <= ST_DOT;
          end
        end
        default: begin
          seizure <= ~sum_q[AW-1] & (|sum_q);
          valid   <= 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

module svm_lin_classify_chk #(
  parameter int LAT = 17
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic valid,
  input logic seizure
);
  int cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= 0;
    else if (start && !busy) cnt <= 0;
    else if (busy) cnt <= cnt + 1;
  end

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) valid |=> !valid);
  // R6
  class_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !valid |-> $stable(seizure));
  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n) valid |-> cnt == LAT);
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  // R10
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n) (valid && start) |=> busy);
  // R1
  reset_out_chk: assert property (@(posedge clk) (!rst_n) |-> (!valid && !seizure));
endmodule

bind svm_lin_classify svm_lin_classify_chk #(.LAT(NSV*(NFEAT+1)+1)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .valid(valid), .seizure(seizure)
);

// File: tb/svm_lin_classify_tb.sv
`timescale 1ns/1ps
module svm_lin_classify_tb_top;
  localparam int W = 16, NF = 3, NS = 4, FR = 8;
  localparam int LAT = NS*(NF+1)+1;
  localparam logic [NS*NF*W-1:0] SVI = {16'(128), 16'(-256), 16'(-256),
                                        16'(-400), 16'(50), 16'(50),
                                        16'(100), 16'(300), 16'(-200),
                                        16'(64), 16'(-128), 16'(256)};
  localparam logic [NS*W-1:0] ALI = {16'd32, 16'd200, 16'd64, 16'd128};
  localparam logic [NS-1:0]   LBI = 4'b1010;
  localparam logic [W-1:0]    BIAS_I = 16'(-64);

  logic clk = 0, rst_n = 0, start = 0;
  logic [NF*W-1:0] feat = '0;
  logic cls_i, val_i, cls_z, val_z;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  svm_lin_classify #(.W(W), .NFEAT(NF), .NSV(NS), .FRAC(FR), .SV_INIT(SVI),
    .ALPHA_INIT(ALI), .LABEL_INIT(LBI), .BIAS(BIAS_I)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .feat_in(feat), .seizure(cls_i), .valid(val_i));

  svm_lin_classify #(.W(W), .NFEAT(NF), .NSV(NS), .FRAC(FR), .SV_INIT(SVI),
    .ALPHA_INIT(ALI), .LABEL_INIT(LBI), .BIAS(16'd0)) dut_z (
    .clk(clk), .rst_n(rst_n), .start(start), .feat_in(feat), .seizure(cls_z), .valid(val_z));

  function automatic bit model(input logic [NF*W-1:0] x, input longint bias);
    longint sum = bias;
    for (int s = 0; s < NS; s++) begin
      longint dot = 0, dq, m, t;
      for (int f = 0; f < NF; f++)
        dot += longint'($signed(x[f*W +: W])) * longint'($signed(SVI[(s*NF+f)*W +: W]));
      dq = longint'($signed(16'(dot >>> FR)));
      m  = longint'(ALI[s*W +: W-1]);
      t  = (m * dq) >>> FR;
      if (ALI[s*W+W-1] ^ LBI[s]) t = -t;
      sum += t;
    end
    return sum > 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [NF*W-1:0] vec(input int a, input int b, input int c);
    return {16'(c), 16'(b), 16'(a)};
  endfunction

  task automatic xact(input logic [NF*W-1:0] x, input bit disturb);
    int lat = 0;
    feat = x; start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    if (disturb) begin feat = ~x; start = 1; end
    while (!val_i && lat < 100) begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (disturb && lat == 5) start = 0;
    end
    chk(lat == LAT, "R7 latency", lat, LAT);
    chk(val_z == 1'b1, "R7 valid both", int'(val_z), 1);
    chk(cls_i == model(x, -64), disturb ? "R8/R9 class latched" : "R2/R3/R4 class",
        int'(cls_i), int'(model(x, -64)));
    chk(cls_z == model(x, 0), "R5 class zero bias", int'(cls_z), int'(model(x, 0)));
  endtask

  task automatic after_result();
    logic c = cls_i;
    @(negedge clk);
    chk(val_i == 1'b0, "R6 pulse", int'(val_i), 0);
    @(negedge clk);
    chk(cls_i == c, "R6 hold", int'(cls_i), int'(c));
  endtask

  initial begin
    #(200000*8);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(11));
    repeat (3) @(negedge clk);
    chk(val_i == 0 && cls_i == 0, "R1 reset held", int'({val_i, cls_i}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(val_i == 0 && cls_i == 0, "R1 after reset", int'({val_i, cls_i}), 0);

    xact(vec(0, 0, 0), 0);
    chk(cls_z == 1'b0, "R5 exact zero", int'(cls_z), 0);
    after_result();
    xact(vec(256, -128, 64), 0);
    after_result();
    xact(vec(-200, 300, 100), 0);
    after_result();
    xact(vec(1, 0, 0), 0);
    after_result();
    xact(vec(300, 10, -90), 1);
    after_result();
    xact(vec(256, -128, 64), 0);
    xact(vec(-256, -256, 128), 0);
    chk(1'b1, "R10 back-to-back accepted", 1, 1);
    xact(vec(50, 50, -400), 0);
    after_result();

    for (int i = 0; i < 40; i++) begin
      logic [NF*W-1:0] x;
      for (int f = 0; f < NF; f++) x[f*W +: W] = 16'(int'($urandom % 1024) - 512);
      xact(x, ($urandom % 4) == 0);
      if (($urandom % 3) != 0) after_result();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule